// File: doc/BRIEF.md
# Pipelined Instruction-Fetch Line Responder

This block is the slave end of an instruction-fetch path. A master presents a word address together with a line size (four or eight words), a cacheable flag and one user attribute bit. The slave grants the request combinationally in the same cycle it is offered and stores the request. After a fixed latency it streams the whole line back, one word per cycle, each word marked by a read-data acknowledge.

Up to two granted requests can wait in the slave at once, so a prefetch can be granted while the previous line is still pending. Lines always come back in the order they were granted. The word values come from a combinational read port computed from the address. The master can withdraw an offer with an abort strobe; a withdrawn offer is never granted and never served.

Top module: `ifl_slave`

## Requirements
- R1: `addr_ack` is high in the same cycle as `req_valid` when `req_abort` is low and fewer than two requests are stored.
- R2: The request fields are sampled in the grant cycle. The `req_cacheable` and `req_attr` values of that cycle reappear on `rd_cacheable`/`rd_attr` with every word of the line, whatever the inputs do later.
- R3: With `req_size8`=0 the line holds four words, and its base is the byte address with bits [3:0] cleared.
- R4: With `req_size8`=1 the line holds eight words, and its base is the byte address with bits [4:0] cleared.
- R5: Words of a line are returned with ascending addresses in steps of 4 bytes, one `rd_ack` per word, in consecutive cycles. `rd_last` is high on the final word only.
- R6: When no earlier line is still being returned, the first word of a line appears exactly LATENCY cycles after its grant cycle. Otherwise it appears at whichever is later: that point, or the cycle after the earlier line's last word.
- R7: A second request is granted while the first is still pending. Every word of the earlier line is returned before any word of the later one.
- R8: An offer with `req_abort` high is not granted and produces no data.
- R9: No grant is given while two requests are stored, even in a cycle where a stored line finishes.
- R10: `rd_data` equals the low 32 bits of (byte address / 4) × 2654435769.
- R11: After reset, `rd_ack` and `rd_last` are low and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request offered |
| req_abort | input | 1 | Withdraw the offered request |
| req_addr | input | 32 | Byte address of the fetch (bits [1:0] are zero) |
| req_size8 | input | 1 | 1 = eight-word line, 0 = four-word line |
| req_cacheable | input | 1 | Cacheable flag of the request |
| req_attr | input | 1 | User attribute bit of the request |
| addr_ack | output | 1 | Request granted this cycle |
| rd_ack | output | 1 | A data word is valid this cycle |
| rd_last | output | 1 | Final word of the current line |
| rd_addr | output | 32 | Byte address of the returned word |
| rd_data | output | 32 | Returned word |
| rd_cacheable | output | 1 | Cacheable flag of the line being returned |
| rd_attr | output | 1 | Attribute bit of the line being returned |

## Verification
A wrong read or write pointer in the two-entry store shows up at the first word of the next line. That line then carries the wrong base address, data or attribute bits, or it comes back in the wrong order. A wrong occupancy count shows up as a grant while two lines are pending, which yields a thirteenth word in the overlap test, or as a missing grant in the very cycle of the offer. A faulty beat counter or latency timer shows within one line: a word address out of step, `rd_last` on the wrong word, or a first word off the LATENCY-cycle mark.

// File: rtl/ifl_pkg.sv
`timescale 1ns/1ps
package ifl_pkg;
  localparam int unsigned IFL_AW        = 32;
  localparam int unsigned IFL_DW        = 32;
  localparam int unsigned IFL_MAX_BEATS = 8;
  localparam int unsigned IFL_BEAT_W    = $clog2(IFL_MAX_BEATS);
  localparam int unsigned IFL_WORD_B    = 4;

  typedef struct packed {
    logic [IFL_AW-1:0] base;
    logic              size8;
    logic              cacheable;
    logic              attr;
  } ifl_req_t;

  // Align a byte address down to the start of its line.
  function automatic logic [IFL_AW-1:0] ifl_line_base(input logic [IFL_AW-1:0] a,
                                                      input logic size8);
    if (size8) return a & ~IFL_AW'(IFL_MAX_BEATS * IFL_WORD_B - 1);
    else       return a & ~IFL_AW'(IFL_MAX_BEATS * IFL_WORD_B / 2 - 1);
  endfunction

  // Index of the final word of a line.
  function automatic logic [IFL_BEAT_W-1:0] ifl_last_beat(input logic size8);
    return size8 ? IFL_BEAT_W'(IFL_MAX_BEATS - 1) : IFL_BEAT_W'(IFL_MAX_BEATS / 2 - 1);
  endfunction

  // Byte address of word number beat within a line.
  function automatic logic [IFL_AW-1:0] ifl_word_addr(input logic [IFL_AW-1:0] base,
                                                      input logic [IFL_BEAT_W-1:0] beat);
    return base + (IFL_AW'(beat) * IFL_AW'(IFL_WORD_B));
  endfunction

  // Combinational read port: content derived from the word index.
  function automatic logic [IFL_DW-1:0] ifl_word_value(input logic [IFL_AW-1:0] a);
    logic [IFL_DW-1:0] idx;
    idx = IFL_DW'(a >> 2);
    return idx * IFL_DW'(32'h9E37_79B9);
  endfunction
endpackage

// File: rtl/ifl_req_queue.sv
`timescale 1ns/1ps
module ifl_req_queue
  import ifl_pkg::*;
#(
  parameter int unsigned DEPTH   = 2,
  parameter int unsigned LATENCY = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  ifl_req_t push_req,
  input  logic     pop,
  output ifl_req_t head_req,
  output logic     head_ready,
  output logic     full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned TMR_W = $clog2(LATENCY + 1);

  ifl_req_t           slot_q  [DEPTH];
  logic [TMR_W-1:0]   timer_q [DEPTH];
  logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]   count_q;
  logic               head_valid;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // One storage slot with its own latency timer per entry.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g]  <= '0;
        timer_q[g] <= '0;
      end else if (push && wr_ptr_q == PTR_W'(g)) begin
        slot_q[g]  <= push_req;
        timer_q[g] <= TMR_W'(LATENCY - 1);
      end else if (timer_q[g] != '0) begin
        timer_q[g] <= timer_q[g] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_valid = (count_q != '0);
  assign head_req   = slot_q[rd_ptr_q];
  assign head_ready = head_valid && (timer_q[rd_ptr_q] == '0);
  assign full       = (count_q == CNT_W'(DEPTH));
  assign count      = count_q;

  // A push into a full store would overwrite a pending line.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("push while store full");

  // Lines are only retired once they were stored (in-order drain).
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid) else $error("pop of empty store");
endmodule

// File: rtl/ifl_beat_engine.sv
`timescale 1ns/1ps
module ifl_beat_engine
  import ifl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ifl_req_t          head_req,
  input  logic              head_ready,
  output logic              rd_ack,
  output logic              rd_last,
  output logic [IFL_AW-1:0] rd_addr,
  output logic [IFL_DW-1:0] rd_data,
  output logic              rd_cacheable,
  output logic              rd_attr,
  output logic              line_done
);
  logic [IFL_BEAT_W-1:0] beat_q;
  logic                  at_last;

  assign at_last      = (beat_q == ifl_last_beat(head_req.size8));
  assign rd_ack       = head_ready;
  assign rd_last      = head_ready && at_last;
  assign rd_addr      = ifl_word_addr(head_req.base, beat_q);
  assign rd_data      = ifl_word_value(rd_addr);
  assign rd_cacheable = head_req.cacheable;
  assign rd_attr      = head_req.attr;
  assign line_done    = rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n)      beat_q <= '0;
    else if (rd_ack) beat_q <= at_last ? '0 : beat_q + 1'b1;
  end

  // Words of one line follow back to back, 4 bytes apart.
  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !rd_last) |=> (rd_ack && rd_addr == $past(rd_addr) + IFL_AW'(IFL_WORD_B)))
    else $error("word sequence broken");

  // The first word of every line sits on its size-dependent boundary.
  assert_line_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && beat_q == '0) |-> (rd_addr[3:0] == 4'd0 && (!head_req.size8 || !rd_addr[4])))
    else $error("line start misaligned");
endmodule

// File: rtl/ifl_slave.sv
`timescale 1ns/1ps
module ifl_slave
  import ifl_pkg::*;
#(
  parameter int unsigned LATENCY = 3,
  parameter int unsigned DEPTH   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_abort,
  input  logic [31:0] req_addr,
  input  logic        req_size8,
  input  logic        req_cacheable,
  input  logic        req_attr,
  output logic        addr_ack,
  output logic        rd_ack,
  output logic        rd_last,
  output logic [31:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_cacheable,
  output logic        rd_attr
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  ifl_req_t          cap_req;
  ifl_req_t          head_req;
  logic              head_ready;
  logic              q_full;
  logic [CNT_W-1:0]  q_count;
  logic              line_done;

  // Grant decision: same-cycle, blocked by abort or a full store.
  assign addr_ack = req_valid && !req_abort && !q_full;

  assign cap_req.base      = ifl_line_base(req_addr, req_size8);
  assign cap_req.size8     = req_size8;
  assign cap_req.cacheable = req_cacheable;
  assign cap_req.attr      = req_attr;

  ifl_req_queue #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (addr_ack),
    .push_req   (cap_req),
    .pop        (line_done),
    .head_req   (head_req),
    .head_ready (head_ready),
    .full       (q_full),
    .count      (q_count)
  );

  ifl_beat_engine u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_req     (head_req),
    .head_ready   (head_ready),
    .rd_ack       (rd_ack),
    .rd_last      (rd_last),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .rd_cacheable (rd_cacheable),
    .rd_attr      (rd_attr),
    .line_done    (line_done)
  );

  // A withdrawn offer is never granted.
  assert_abort_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_abort) |-> !addr_ack) else $error("aborted offer granted");

  // With nothing stored, no word may be returned.
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == '0) |-> !rd_ack) else $error("data with empty store");
endmodule

// File: tb/test_ifl_slave.sv
`timescale 1ns/1ps
module test_ifl_slave;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_abort = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_size8 = 1'b0, req_cacheable = 1'b0, req_attr = 1'b0;
  logic        addr_ack, rd_ack, rd_last, rd_cacheable, rd_attr;
  logic [31:0] rd_addr, rd_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic [31:0] m_addr [64];
  logic [31:0] m_data [64];
  logic        m_cach [64];
  logic        m_attr [64];
  logic        m_last [64];
  int          m_cyc  [64];
  int          m_n = 0;

  ifl_slave #(.LATENCY(LAT), .DEPTH(2)) i_ifl_slave (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_abort(req_abort),
    .req_addr(req_addr), .req_size8(req_size8), .req_cacheable(req_cacheable),
    .req_attr(req_attr), .addr_ack(addr_ack), .rd_ack(rd_ack), .rd_last(rd_last),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_cacheable(rd_cacheable), .rd_attr(rd_attr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && rd_ack && m_n < 64) begin
      m_addr[m_n] = rd_addr; m_data[m_n] = rd_data; m_cach[m_n] = rd_cacheable;
      m_attr[m_n] = rd_attr; m_last[m_n] = rd_last; m_cyc[m_n] = cyc;
      m_n++;
    end
  end

  function automatic logic [31:0] exp_data(input logic [31:0] a);
    logic [63:0] p;
    p = {32'd0, 2'b00, a[31:2]} * 64'd2654435769;
    return p[31:0];
  endfunction

  function automatic logic [31:0] exp_base(input logic [31:0] a, input bit s8);
    return a - (a % (s8 ? 32'd32 : 32'd16));
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input bit s8, input bit c, input bit at,
                       input bit ab, output bit acked, output int ack_cyc);
    @(posedge clk); #1;
    req_valid = 1; req_abort = ab; req_addr = a; req_size8 = s8; req_cacheable = c; req_attr = at;
    @(negedge clk);
    acked = addr_ack; ack_cyc = cyc;
    @(posedge clk); #1;
    // Fields change after the grant; R2 says they must not matter.
    req_valid = 0; req_abort = 0; req_addr = ~a; req_size8 = ~s8; req_cacheable = ~c; req_attr = ~at;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_line(input int start, input logic [31:0] a, input bit s8, input bit c,
                            input bit at, input int first_cyc, input string rq);
    int nb;
    logic [31:0] base;
    nb = s8 ? 8 : 4;
    base = exp_base(a, s8);
    for (int k = 0; k < nb; k++) begin
      chk(rq, "word address (R3 R4 R5)", m_addr[start+k], base + 32'(4*k));
      chk(rq, "word data R10", m_data[start+k], exp_data(base + 32'(4*k)));
      chk(rq, "cacheable R2", {31'd0, m_cach[start+k]}, {31'd0, c});
      chk(rq, "attribute R2", {31'd0, m_attr[start+k]}, {31'd0, at});
      chk(rq, "last marker R5", {31'd0, m_last[start+k]}, {31'd0, (k == nb-1)});
      chk(rq, "word cycle R6", 32'(m_cyc[start+k]), 32'(first_cyc + k));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11", "rd_ack after reset", {31'd0, rd_ack}, 32'd0);
    chk("R11", "rd_last after reset", {31'd0, rd_last}, 32'd0);
    chk("R11", "no grant without offer", {31'd0, addr_ack}, 32'd0);
  endtask

  task automatic t_four;
    bit ok; int ac;
    m_n = 0;
    drive(32'h1000_0034, 0, 1, 0, 0, ok, ac);
    chk("R1", "same-cycle grant", {31'd0, ok}, 32'd1);
    idle(LAT + 12);
    chk("R3", "four-word count", 32'(m_n), 32'd4);
    check_line(0, 32'h1000_0034, 0, 1, 0, ac + LAT, "R3");
  endtask

  task automatic t_eight;
    bit ok; int ac;
    m_n = 0;
    drive(32'h2000_0074, 1, 0, 1, 0, ok, ac);
    chk("R1", "same-cycle grant", {31'd0, ok}, 32'd1);
    idle(LAT + 16);
    chk("R4", "eight-word count", 32'(m_n), 32'd8);
    check_line(0, 32'h2000_0074, 1, 0, 1, ac + LAT, "R4");
  endtask

  task automatic t_pipe;
    bit oka, okb, okc; int aa, ab, acc, fb;
    m_n = 0;
    drive(32'h3000_00A8, 1, 1, 1, 0, oka, aa);
    drive(32'h4000_0018, 0, 0, 0, 0, okb, ab);
    drive(32'h5000_0000, 0, 1, 1, 0, okc, acc);
    chk("R7", "first of pair granted", {31'd0, oka}, 32'd1);
    chk("R7", "second granted while first pending", {31'd0, okb}, 32'd1);
    chk("R9", "third refused while two stored", {31'd0, okc}, 32'd0);
    idle(LAT + 30);
    chk("R9", "refused request produced no data", 32'(m_n), 32'd12);
    check_line(0, 32'h3000_00A8, 1, 1, 1, aa + LAT, "R7");
    fb = (ab + LAT > aa + LAT + 8) ? ab + LAT : aa + LAT + 8;
    check_line(8, 32'h4000_0018, 0, 0, 0, fb, "R6");
  endtask

  task automatic t_abort;
    bit ok; int ac;
    m_n = 0;
    drive(32'h6000_0040, 1, 1, 1, 1, ok, ac);
    chk("R8", "aborted offer not granted", {31'd0, ok}, 32'd0);
    idle(LAT + 14);
    chk("R8", "aborted offer not served", 32'(m_n), 32'd0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_four;
    t_eight;
    t_pipe;
    t_abort;
    done = 1;
    report;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report;
      $finish;
    end
  end
endmodule